// File: doc/BRIEF.md
# Per-Bank Page-Policy Command Sequencer

This block sequences the DRAM commands for one bank of a memory controller. It holds no request queue: a single pending read or write request, with its target row and a write flag, is presented on a valid/ready handshake. The block tracks whether its bank is idle (precharged) or has a row open. From that state and the request it proposes the next DRAM command: activate, read, write, read with auto-precharge, write with auto-precharge, or precharge. It issues that command only when an external timing checker reports that the command is legal in the current cycle.

The page policy is fixed by a parameter. Open keeps rows open after a column access. Closed always auto-precharges. The two adaptive variants decide on each row hit from two look-ahead hints supplied by the queue logic. Each candidate command carries the bank's rank, bank group and flat bank index, so a shared checker can look up its timing windows. The rank and group are derived arithmetically from the flat bank index.

Top module: `bank_page_ctrl`

## Requirements
- R1: After reset the bank is precharged. With no request valid, `cmd_type` is NOP (code 0) and `cmd_issue` and `req_ready` are low. Command codes are NOP 0, ACT 1, RD 2, WR 3, RDA 4, WRA 5, PRE 6.
- R2: With a valid request and the bank precharged, the candidate is ACT (1). Once it is issued, the requested row becomes the open row.
- R3: With a row open that differs from the requested row, the candidate is PRE (6). Once it is issued, the bank is precharged. `cmd_row` shows the open row while a row is open, the requested row while the bank is precharged and a request is valid, and 0 otherwise.
- R4: Under the open policy (POLICY 0), a row hit yields RD (2) or WR (3) and the row stays open.
- R5: Under the closed policy (POLICY 1), a row hit yields RDA (4) or WRA (5) and the bank returns to precharged.
- R6: Under open-adaptive (POLICY 2), a row hit auto-precharges only when `hint_same_row` is 0 and `hint_other_row` is 1. Otherwise it issues the plain column command.
- R7: Under closed-adaptive (POLICY 3), a row hit issues the plain column command only when `hint_same_row` is 1. Otherwise it auto-precharges.
- R8: Under closed-adaptive, `policy_error` is high exactly while a valid request misses an open row. The PRE candidate is still offered. Under the other policies `policy_error` stays low.
- R9: `cmd_issue` is high exactly when a request is valid and `cmd_go` is high. The bank state changes only on an issued command.
- R10: `req_ready` is high exactly in a cycle where an RD, WR, RDA or WRA command issues.
- R11: `cmd_rank` equals BANK_ID/(NUM_BANKS/NUM_RANKS), `cmd_group` equals BANK_ID/(NUM_BANKS/NUM_GROUPS), and `cmd_bank` equals BANK_ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Pending request present |
| req_ready | output | 1 | Request consumed this cycle |
| req_row | input | ROW_W | Target row of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| hint_same_row | input | 1 | Another queued request targets the same row |
| hint_other_row | input | 1 | Another queued request targets a different row |
| cmd_go | input | 1 | Checker: candidate command is legal now |
| cmd_valid | output | 1 | Candidate command present |
| cmd_type | output | 3 | Candidate command code |
| cmd_row | output | ROW_W | Row associated with the candidate |
| cmd_rank | output | RANK_W | Rank index of this bank |
| cmd_group | output | GROUP_W | Bank-group index of this bank |
| cmd_bank | output | BANK_W | Flat bank index |
| cmd_issue | output | 1 | Candidate command issued this cycle |
| policy_error | output | 1 | Row miss seen under closed-adaptive policy |

## Verification
The assertions assume that the requester holds `req_row`, `req_write` and the two hints steady from the cycle `req_valid` rises until `req_ready` is seen. They also assume that `cmd_go` is judged only against the candidate shown in the same cycle. The stimulus draws a fresh request only in the cycle after a consumption, and it changes the hints only together with the request. `cmd_go` toggles freely, so commands are held back for random stretches. Rows are drawn from a small set that includes the widest row value, so hits, misses and closed-adaptive errors all occur often.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_RDA = 3'd4,
    CMD_WRA = 3'd5,
    CMD_PRE = 3'd6
  } bpc_cmd_e;

  localparam int POL_OPEN        = 0;
  localparam int POL_CLOSED      = 1;
  localparam int POL_OPEN_ADPT   = 2;
  localparam int POL_CLOSED_ADPT = 3;

  function automatic logic is_column(bpc_cmd_e c);
    return (c == CMD_RD) || (c == CMD_WR) || (c == CMD_RDA) || (c == CMD_WRA);
  endfunction

  function automatic logic closes_row(bpc_cmd_e c);
    return (c == CMD_PRE) || (c == CMD_RDA) || (c == CMD_WRA);
  endfunction
endpackage

// File: rtl/bpc_coords.sv
module bpc_coords #(
  parameter int NUM_BANKS  = 16,
  parameter int NUM_RANKS  = 2,
  parameter int NUM_GROUPS = 4,
  parameter int BANK_ID    = 11,
  localparam int RANK_W  = (NUM_RANKS  > 1) ? $clog2(NUM_RANKS)  : 1,
  localparam int GROUP_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int BANK_W  = (NUM_BANKS  > 1) ? $clog2(NUM_BANKS)  : 1
) (
  output logic [RANK_W-1:0]  rank_idx,
  output logic [GROUP_W-1:0] group_idx,
  output logic [BANK_W-1:0]  bank_idx
);
  localparam int BANKS_PER_RANK  = NUM_BANKS / NUM_RANKS;
  localparam int BANKS_PER_GROUP = NUM_BANKS / NUM_GROUPS;
  localparam int RANK_VAL  = BANK_ID / BANKS_PER_RANK;
  localparam int GROUP_VAL = BANK_ID / BANKS_PER_GROUP;

  generate
    if (NUM_RANKS > 1) begin : g_multi_rank
      assign rank_idx = RANK_W'(RANK_VAL);
    end else begin : g_single_rank
      assign rank_idx = '0;
    end
    if (NUM_GROUPS > 1) begin : g_multi_group
      assign group_idx = GROUP_W'(GROUP_VAL);
    end else begin : g_single_group
      assign group_idx = '0;
    end
  endgenerate

  assign bank_idx = BANK_W'(BANK_ID);
endmodule

// File: rtl/bpc_decide.sv
module bpc_decide
  import bpc_pkg::*;
#(
  parameter int ROW_W  = 14,
  parameter int POLICY = POL_OPEN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bank_open,
  input  logic [ROW_W-1:0] open_row,
  input  logic             req_valid,
  input  logic [ROW_W-1:0] req_row,
  input  logic             req_write,
  input  logic             hint_same_row,
  input  logic             hint_other_row,
  output logic             cand_valid,
  output bpc_cmd_e         cand_cmd,
  output logic [ROW_W-1:0] cand_row,
  output logic             miss_error
);
  logic row_miss;
  logic auto_pre;

  assign row_miss = bank_open && (open_row != req_row);

  always_comb begin
    case (POLICY)
      POL_CLOSED:      auto_pre = 1'b1;
      POL_OPEN_ADPT:   auto_pre = !hint_same_row && hint_other_row;
      POL_CLOSED_ADPT: auto_pre = !hint_same_row;
      default:         auto_pre = 1'b0;
    endcase
  end

  always_comb begin
    cand_valid = req_valid;
    if (!req_valid) begin
      cand_cmd = CMD_NOP;
    end else if (!bank_open) begin
      cand_cmd = CMD_ACT;
    end else if (row_miss) begin
      cand_cmd = CMD_PRE;
    end else if (req_write) begin
      cand_cmd = auto_pre ? CMD_WRA : CMD_WR;
    end else begin
      cand_cmd = auto_pre ? CMD_RDA : CMD_RD;
    end
  end

  always_comb begin
    if (bank_open) begin
      cand_row = open_row;
    end else if (req_valid) begin
      cand_row = req_row;
    end else begin
      cand_row = '0;
    end
  end

  assign miss_error = (POLICY == POL_CLOSED_ADPT) && req_valid && row_miss;

  // R2: a closed bank with a request can only be offered an activate
  assert_closed_bank_act_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !bank_open) |-> (cand_cmd == CMD_ACT));

  // R8: the error flag coincides with a precharge candidate
  assert_error_is_pre_R8: assert property (@(posedge clk) disable iff (!rst_n)
    miss_error |-> (cand_cmd == CMD_PRE));

  generate
    if (POLICY == POL_OPEN) begin : g_chk_open
      assert_open_no_autopre_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !((cand_cmd == CMD_RDA) || (cand_cmd == CMD_WRA)));
    end
    if (POLICY == POL_CLOSED) begin : g_chk_closed
      assert_closed_autopre_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !((cand_cmd == CMD_RD) || (cand_cmd == CMD_WR)));
    end
  endgenerate
endmodule

// File: rtl/bpc_state.sv
module bpc_state
  import bpc_pkg::*;
#(
  parameter int ROW_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  bpc_cmd_e         issue_cmd,
  input  logic [ROW_W-1:0] act_row,
  output logic             bank_open,
  output logic [ROW_W-1:0] open_row
);
  logic             open_q, open_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             upd_en;

  assign upd_en = issue && ((issue_cmd == CMD_ACT) || closes_row(issue_cmd));

  always_comb begin
    open_d = open_q;
    row_d  = row_q;
    if (issue_cmd == CMD_ACT) begin
      open_d = 1'b1;
      row_d  = act_row;
    end else begin
      open_d = 1'b0;
      row_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (upd_en) begin
      open_q <= open_d;
      row_q  <= row_d;
    end
  end

  assign bank_open = open_q;
  assign open_row  = row_q;

  // R9: without an issued command the bank state holds
  assert_hold_without_issue_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> ($stable(open_q) && $stable(row_q)));

  // R2: an issued activate opens the requested row
  assert_act_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && issue_cmd == CMD_ACT) |=> (open_q && row_q == $past(act_row)));

  // R3: precharge or auto-precharge leaves the bank closed
  assert_close_on_pre_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && closes_row(issue_cmd)) |=> !open_q);
endmodule

// File: rtl/bank_page_ctrl.sv
module bank_page_ctrl
  import bpc_pkg::*;
#(
  parameter int ROW_W      = 14,
  parameter int NUM_BANKS  = 16,
  parameter int NUM_RANKS  = 2,
  parameter int NUM_GROUPS = 4,
  parameter int BANK_ID    = 11,
  parameter int POLICY     = 0,
  localparam int RANK_W  = (NUM_RANKS  > 1) ? $clog2(NUM_RANKS)  : 1,
  localparam int GROUP_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int BANK_W  = (NUM_BANKS  > 1) ? $clog2(NUM_BANKS)  : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ROW_W-1:0]   req_row,
  input  logic               req_write,
  input  logic               hint_same_row,
  input  logic               hint_other_row,
  input  logic               cmd_go,
  output logic               cmd_valid,
  output logic [2:0]         cmd_type,
  output logic [ROW_W-1:0]   cmd_row,
  output logic [RANK_W-1:0]  cmd_rank,
  output logic [GROUP_W-1:0] cmd_group,
  output logic [BANK_W-1:0]  cmd_bank,
  output logic               cmd_issue,
  output logic               policy_error
);
  logic             bank_open;
  logic [ROW_W-1:0] open_row;
  logic             cand_valid;
  bpc_cmd_e         cand_cmd;
  logic             issue;

  bpc_coords #(
    .NUM_BANKS(NUM_BANKS), .NUM_RANKS(NUM_RANKS),
    .NUM_GROUPS(NUM_GROUPS), .BANK_ID(BANK_ID)
  ) u_coords (
    .rank_idx(cmd_rank), .group_idx(cmd_group), .bank_idx(cmd_bank)
  );

  bpc_decide #(.ROW_W(ROW_W), .POLICY(POLICY)) u_decide (
    .clk(clk), .rst_n(rst_n),
    .bank_open(bank_open), .open_row(open_row),
    .req_valid(req_valid), .req_row(req_row), .req_write(req_write),
    .hint_same_row(hint_same_row), .hint_other_row(hint_other_row),
    .cand_valid(cand_valid), .cand_cmd(cand_cmd), .cand_row(cmd_row),
    .miss_error(policy_error)
  );

  assign issue = cand_valid && cmd_go;

  bpc_state #(.ROW_W(ROW_W)) u_state (
    .clk(clk), .rst_n(rst_n),
    .issue(issue), .issue_cmd(cand_cmd), .act_row(req_row),
    .bank_open(bank_open), .open_row(open_row)
  );

  assign cmd_valid = cand_valid;
  assign cmd_type  = cand_cmd;
  assign cmd_issue = issue;
  assign req_ready = issue && is_column(cand_cmd);

  // R10: consumption happens only with an issued column command
  assert_ready_on_column_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cmd_issue && cmd_type inside {3'd2, 3'd3, 3'd4, 3'd5}));

  // R9: nothing issues without the checker's go
  assert_issue_needs_go_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_issue |-> (cmd_go && cmd_valid));
endmodule

// File: tb/bank_page_ctrl_bench.sv
module bank_page_ctrl_bench;
  localparam int ROW_W = 14;
  localparam int NP    = 4;
  localparam int NCYC  = 4000;

  logic clk;
  logic rst_n;

  logic             rv   [NP];
  logic [ROW_W-1:0] rrow [NP];
  logic             rwr  [NP];
  logic             hs   [NP];
  logic             ho   [NP];
  logic             go   [NP];
  logic             rdy  [NP];
  logic             cval [NP];
  logic [2:0]       ctyp [NP];
  logic [ROW_W-1:0] crow [NP];
  logic             crank[NP];
  logic [1:0]       cgrp [NP];
  logic [3:0]       cbank[NP];
  logic             ciss [NP];
  logic             perr [NP];

  int tests_run;
  int tests_failed;
  int cycles;
  bit done;

  // behavioural reference state per policy
  bit m_open [NP];
  int m_row  [NP];
  bit took   [NP];

  initial clk = 1'b0;
  always #10 clk = ~clk;

  for (genvar p = 0; p < NP; p++) begin : g_pol
    bank_page_ctrl #(
      .ROW_W(ROW_W), .NUM_BANKS(16), .NUM_RANKS(2), .NUM_GROUPS(4),
      .BANK_ID(3 + 4 * p), .POLICY(p)
    ) u_bank_page_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(rv[p]), .req_ready(rdy[p]), .req_row(rrow[p]),
      .req_write(rwr[p]), .hint_same_row(hs[p]), .hint_other_row(ho[p]),
      .cmd_go(go[p]), .cmd_valid(cval[p]), .cmd_type(ctyp[p]),
      .cmd_row(crow[p]), .cmd_rank(crank[p]), .cmd_group(cgrp[p]),
      .cmd_bank(cbank[p]), .cmd_issue(ciss[p]), .policy_error(perr[p])
    );
  end

  task automatic check(input bit ok, input string tag, input int p,
                       input int act, input int exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s policy=%0d actual=%0d expected=%0d time=%0t",
               tag, p, act, exp, $time);
    end
  endtask

  function automatic int pick_row();
    int r = int'($urandom % 5);
    return (r == 4) ? 16383 : r;
  endfunction

  // reference comparison on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int p = 0; p < NP; p++) begin
        int e_type, e_row;
        bit e_iss, e_rdy, e_err, hit, ap;
        string tag;
        hit = m_open[p] && (m_row[p] == int'(rrow[p]));
        case (p)
          0: ap = 1'b0;
          1: ap = 1'b1;
          2: ap = !hs[p] && ho[p];
          default: ap = !hs[p];
        endcase
        if (!rv[p]) begin e_type = 0; tag = "R1"; end
        else if (!m_open[p]) begin e_type = 1; tag = "R2"; end
        else if (!hit) begin e_type = 6; tag = "R3"; end
        else begin
          e_type = (rwr[p] ? 3 : 2) + (ap ? 2 : 0);
          tag = (p == 0) ? "R4" : (p == 1) ? "R5" : (p == 2) ? "R6" : "R7";
        end
        e_iss = rv[p] && go[p];
        e_rdy = e_iss && (e_type >= 2 && e_type <= 5);
        e_err = (p == 3) && rv[p] && m_open[p] && !hit;
        e_row = m_open[p] ? m_row[p] : (rv[p] ? int'(rrow[p]) : 0);

        check(int'(ctyp[p]) == e_type, tag, p, int'(ctyp[p]), e_type);
        check(cval[p] == rv[p], "R9", p, int'(cval[p]), int'(rv[p]));
        check(ciss[p] == e_iss, "R9", p, int'(ciss[p]), int'(e_iss));
        check(rdy[p] == e_rdy, "R10", p, int'(rdy[p]), int'(e_rdy));
        check(perr[p] == e_err, "R8", p, int'(perr[p]), int'(e_err));
        check(int'(crow[p]) == e_row, "R3", p, int'(crow[p]), e_row);
        check(int'(crank[p]) == (3 + 4 * p) / 8, "R11", p, int'(crank[p]), (3 + 4 * p) / 8);
        check(int'(cgrp[p]) == (3 + 4 * p) / 4, "R11", p, int'(cgrp[p]), (3 + 4 * p) / 4);
        check(int'(cbank[p]) == 3 + 4 * p, "R11", p, int'(cbank[p]), 3 + 4 * p);

        if (e_iss) begin
          if (e_type == 1) begin
            m_open[p] = 1'b1;
            m_row[p]  = int'(rrow[p]);
          end else if (e_type == 6 || e_type == 4 || e_type == 5) begin
            m_open[p] = 1'b0;
            m_row[p]  = 0;
          end
        end
        took[p] = e_rdy;
      end
    end
  end

  // watchdog
  initial begin
    cycles = 0;
    while (!done && cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, 100000);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  initial begin
    tests_run = 0;
    tests_failed = 0;
    done = 1'b0;
    rst_n = 1'b0;
    for (int p = 0; p < NP; p++) begin
      rv[p] = 1'b0; rrow[p] = '0; rwr[p] = 1'b0;
      hs[p] = 1'b0; ho[p] = 1'b0; go[p] = 1'b0;
      m_open[p] = 1'b0; m_row[p] = 0; took[p] = 1'b0;
    end
    repeat (3) @(negedge clk);
    // reset state: idle outputs (R1)
    for (int p = 0; p < NP; p++) begin
      check(ctyp[p] == 3'd0, "R1", p, int'(ctyp[p]), 0);
      check(ciss[p] == 1'b0, "R1", p, int'(ciss[p]), 0);
      check(rdy[p] == 1'b0, "R1", p, int'(rdy[p]), 0);
    end
    rst_n = 1'b1;
    for (int c = 0; c < NCYC; c++) begin
      @(posedge clk);
      #1;
      for (int p = 0; p < NP; p++) begin
        if (!rv[p] || took[p]) begin
          took[p] = 1'b0;
          if (($urandom % 4) != 0) begin
            rv[p]   = 1'b1;
            rrow[p] = ROW_W'(pick_row());
            rwr[p]  = 1'($urandom % 2);
            hs[p]   = 1'($urandom % 2);
            ho[p]   = 1'($urandom % 2);
          end else begin
            rv[p] = 1'b0;
          end
        end
        go[p] = (($urandom % 5) < 3);
      end
    end
    @(posedge clk);
    #1;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule